// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block decides whether the processor may execute one of four privileged instructions: wait-for-interrupt, the supervisor translation fence, and the two hypervisor translation fences (virtual-address and guest-physical). Each decision uses the current privilege level, the virtualization state, the presence of the supervisor and hypervisor extensions, and four trap-control bits. For every valid request it reports exactly one verdict: illegal instruction, virtual-instruction fault, or granted.

A granted wait raises a halt request. The request stays up until the wake input is seen. A granted fence raises a one-cycle flush pulse, which the translation logic downstream acts on. The verdict can be registered, with results appearing one cycle after the request (the default), or passed straight through the combinational rules. A parameter selects between the two.

Top module: `priv_insn_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, out_illegal, out_vfault, out_grant, out_flush and out_halt are all 0.
- R2: For a request presented with req_valid=1, exactly one of out_illegal, out_vfault or out_grant is 1 in the following cycle, for one cycle. A cycle with req_valid=0 produces none of them in the following cycle.
- R3: Wait (class code 0) is illegal in either of two cases. The first is ctl_tw=1 with supervisor privilege (code 1), or with user privilege (code 0) when has_s_ext=0. The second is user privilege with has_s_ext=1 and virt_on=0.
- R4: A wait that is not illegal gives a virtual-instruction fault when virt_on=1 and the privilege is user, or when virt_on=1 with supervisor privilege and ctl_vtw=1. Every other wait is granted, including any wait in machine privilege (code 3).
- R5: The supervisor fence (class code 1) is illegal in user privilege, and in supervisor privilege with ctl_tvm=1. Otherwise it gives a virtual-instruction fault when has_h_ext=1, virt_on=1 and ctl_vtvm=1. In every other case it is granted.
- R6: The hypervisor virtual-address fence (class code 2) gives a virtual-instruction fault in supervisor privilege with virt_on=1. It is granted in machine privilege, or in supervisor privilege with virt_on=0. It is illegal in all other cases.
- R7: The hypervisor guest-physical fence (class code 3) is illegal in supervisor privilege with virt_on=0 and ctl_tvm=1. This check comes first; when it does not apply, the rules of R6 decide.
- R8: out_flush is 1 exactly in the cycle in which a fence (class 1, 2 or 3) is granted. A granted wait never raises out_flush.
- R9: out_halt rises together with the grant of a wait. It stays 1 until a cycle in which wake_i=1 has been sampled, and falls on the following cycle. A granted wait registered in the same cycle as wake_i keeps it at 1.
- R10: A class code above 3, or the reserved privilege code 2, gives out_illegal for any combination of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_class | input | CLASS_W | Instruction class: 0 wait, 1 supervisor fence, 2 hypervisor VA fence, 3 hypervisor guest-physical fence |
| cur_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine, 2 reserved |
| virt_on | input | 1 | Hart is running virtualized |
| has_s_ext | input | 1 | Supervisor extension strap |
| has_h_ext | input | 1 | Hypervisor extension strap |
| ctl_tw | input | 1 | Timeout-wait control bit |
| ctl_tvm | input | 1 | Trap-virtual-memory control bit |
| ctl_vtw | input | 1 | Virtualized timeout-wait control bit |
| ctl_vtvm | input | 1 | Virtualized trap-virtual-memory control bit |
| wake_i | input | 1 | Wake event; clears the halt request |
| out_illegal | output | 1 | Illegal-instruction verdict |
| out_vfault | output | 1 | Virtual-instruction fault verdict |
| out_grant | output | 1 | Permission granted |
| out_flush | output | 1 | Translation flush pulse for a granted fence |
| out_halt | output | 1 | Halt request from a granted wait |

## Verification
The rules are tried with a table of requests. For each class, the table sweeps privilege, virtualization, the extension straps and the trap bits. Each entry is chosen to show which branch won: for example, a supervisor wait with ctl_tw set against the same wait virtualized with ctl_vtw set, or a guest-physical fence with ctl_tvm set in supervisor privilege with virtualization off against the same fence with it on. Machine-privilege entries with every trap bit set show that the trap bits have no effect there, and unknown classes or the reserved privilege show the fall-back verdict. Directed sequences then check idle cycles, the hold and release of the halt request, and a wake that arrives together with a new granted wait.

// File: rtl/priv_insn_gate_pkg.sv
package priv_insn_gate_pkg;

   localparam int PRIV_W = 2;

   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPER = 2'd1,
      LVL_RSVD  = 2'd2,
      LVL_MACH  = 2'd3
   } level_e;

   typedef enum logic [1:0] {
      OP_WAIT    = 2'd0,
      OP_SFENCE  = 2'd1,
      OP_HFVA    = 2'd2,
      OP_HFGPA   = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      VD_GRANT = 2'd0,
      VD_ILL   = 2'd1,
      VD_VFLT  = 2'd2
   } verdict_e;

   typedef struct packed {
      logic virt;
      logic ext_s;
      logic ext_h;
      logic tw;
      logic tvm;
      logic vtw;
      logic vtvm;
   } ctl_t;

   function automatic verdict_e rule_wait(level_e lv, ctl_t c);
      logic u, s;
      u = (lv == LVL_USER);
      s = (lv == LVL_SUPER);
      if (((s || (!c.ext_s && u)) && c.tw) || (c.ext_s && u && !c.virt))
         return VD_ILL;
      else if (c.virt && (u || (s && c.vtw)))
         return VD_VFLT;
      else
         return VD_GRANT;
   endfunction

   function automatic verdict_e rule_sfence(level_e lv, ctl_t c);
      if ((lv == LVL_USER) || ((lv == LVL_SUPER) && c.tvm))
         return VD_ILL;
      else if (c.ext_h && c.virt && c.vtvm)
         return VD_VFLT;
      else
         return VD_GRANT;
   endfunction

   function automatic verdict_e rule_hfva(level_e lv, ctl_t c);
      if ((lv == LVL_SUPER) && c.virt)
         return VD_VFLT;
      else if ((lv == LVL_MACH) || ((lv == LVL_SUPER) && !c.virt))
         return VD_GRANT;
      else
         return VD_ILL;
   endfunction

   function automatic verdict_e rule_hfgpa(level_e lv, ctl_t c);
      if ((lv == LVL_SUPER) && !c.virt && c.tvm)
         return VD_ILL;
      else
         return rule_hfva(lv, c);
   endfunction

endpackage

// File: rtl/pic_rule_eval.sv
module pic_rule_eval
   import priv_insn_gate_pkg::*;
#(
   parameter int CLASS_W = 3
) (
   input  logic [CLASS_W-1:0] cls_i,
   input  logic [PRIV_W-1:0]  lvl_i,
   input  ctl_t               ctl_i,
   output verdict_e           verdict_o,
   output logic               is_fence_o
);
   localparam int KNOWN_OPS = 4;

   generate
      if (CLASS_W < 2) begin : g_bad_w
         $error("pic_rule_eval: CLASS_W must be at least 2");
      end
   endgenerate

   logic   known;
   op_e    op;
   level_e lv;

   assign known = ({{(32-CLASS_W){1'b0}}, cls_i} < 32'(KNOWN_OPS));
   assign op    = op_e'(cls_i[1:0]);
   assign lv    = level_e'(lvl_i);

   always_comb begin
      verdict_o  = VD_ILL;
      is_fence_o = 1'b0;
      if (known && (lv != LVL_RSVD)) begin
         unique case (op)
            OP_WAIT:   verdict_o = rule_wait(lv, ctl_i);
            OP_SFENCE: verdict_o = rule_sfence(lv, ctl_i);
            OP_HFVA:   verdict_o = rule_hfva(lv, ctl_i);
            OP_HFGPA:  verdict_o = rule_hfgpa(lv, ctl_i);
            default:   verdict_o = VD_ILL;
         endcase
         is_fence_o = (op != OP_WAIT);
      end
   end

   always_comb begin
      if (!known) assert (verdict_o == VD_ILL)
         else $error("a_r10_unknown_class_illegal");
   end
endmodule

// File: rtl/pic_result_stage.sv
module pic_result_stage
   import priv_insn_gate_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     vld_i,
   input  verdict_e verdict_i,
   input  logic     fence_i,
   output logic     ill_o,
   output logic     vflt_o,
   output logic     grant_o,
   output logic     flush_o
);
   logic ill_d, vflt_d, grant_d, flush_d;

   assign ill_d   = vld_i && (verdict_i == VD_ILL);
   assign vflt_d  = vld_i && (verdict_i == VD_VFLT);
   assign grant_d = vld_i && (verdict_i == VD_GRANT);
   assign flush_d = grant_d && fence_i;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ill_o   <= 1'b0;
               vflt_o  <= 1'b0;
               grant_o <= 1'b0;
               flush_o <= 1'b0;
            end else begin
               ill_o   <= ill_d;
               vflt_o  <= vflt_d;
               grant_o <= grant_d;
               flush_o <= flush_d;
            end
         end

         a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> (ill_o || vflt_o || grant_o));
         a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_i |=> !(ill_o || vflt_o || grant_o || flush_o));
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign ill_o   = ill_d;
         assign vflt_o  = vflt_d;
         assign grant_o = grant_d;
         assign flush_o = flush_d;
      end
   endgenerate
endmodule

// File: rtl/pic_halt_hold.sv
module pic_halt_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wake_i,
   output logic halt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         halt_o <= 1'b0;
      else if (set_i)
         halt_o <= 1'b1;
      else if (wake_i)
         halt_o <= 1'b0;
   end

   a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !wake_i) |=> halt_o);
   a_r9_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_i && !set_i) |=> !halt_o);
endmodule

// File: rtl/priv_insn_gate.sv
module priv_insn_gate
   import priv_insn_gate_pkg::*;
#(
   parameter int CLASS_W = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [CLASS_W-1:0] req_class,
   input  logic [1:0]         cur_priv,
   input  logic               virt_on,
   input  logic               has_s_ext,
   input  logic               has_h_ext,
   input  logic               ctl_tw,
   input  logic               ctl_tvm,
   input  logic               ctl_vtw,
   input  logic               ctl_vtvm,
   input  logic               wake_i,
   output logic               out_illegal,
   output logic               out_vfault,
   output logic               out_grant,
   output logic               out_flush,
   output logic               out_halt
);
   ctl_t     ctl;
   verdict_e verdict;
   logic     is_fence;
   logic     halt_set;

   assign ctl = '{virt: virt_on, ext_s: has_s_ext, ext_h: has_h_ext,
                  tw: ctl_tw, tvm: ctl_tvm, vtw: ctl_vtw, vtvm: ctl_vtvm};

   pic_rule_eval #(.CLASS_W(CLASS_W)) u_eval (
      .cls_i      (req_class),
      .lvl_i      (cur_priv),
      .ctl_i      (ctl),
      .verdict_o  (verdict),
      .is_fence_o (is_fence)
   );

   pic_result_stage #(.REG_OUT(REG_OUT)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld_i     (req_valid),
      .verdict_i (verdict),
      .fence_i   (is_fence),
      .ill_o     (out_illegal),
      .vflt_o    (out_vfault),
      .grant_o   (out_grant),
      .flush_o   (out_flush)
   );

   assign halt_set = req_valid && (verdict == VD_GRANT) && !is_fence;

   pic_halt_hold u_halt (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (halt_set),
      .wake_i (wake_i),
      .halt_o (out_halt)
   );

   a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_illegal, out_vfault, out_grant}));
   a_r8_flush_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      out_flush |-> out_grant);

   generate
      if (REG_OUT) begin : g_reg_chk
         a_r9_halt_rises_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_halt) |-> (out_grant && !out_flush));
         a_r10_reserved_level: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && cur_priv == 2'd2) |=> out_illegal);
      end
   endgenerate
endmodule

// File: tb/priv_insn_gate_test.sv
module priv_insn_gate_test;
   localparam int CW = 3;
   localparam int NV = 26;
   localparam logic [1:0] E_GR = 2'd0, E_IL = 2'd1, E_VF = 2'd2;
   localparam logic [1:0] PU = 2'd0, PS = 2'd1, PR = 2'd2, PM = 2'd3;

   // fields: class, priv, virt, s, h, tw, tvm, vtw, vtvm, expected
   localparam logic [13:0] VEC [NV] = '{
      {3'd0, PS, 1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0, E_IL}, // R3
      {3'd0, PU, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, E_IL}, // R3
      {3'd0, PU, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, E_GR}, // R4
      {3'd0, PU, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, E_IL}, // R3
      {3'd0, PU, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, E_VF}, // R4
      {3'd0, PS, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0, E_VF}, // R4
      {3'd0, PS, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, E_GR}, // R4
      {3'd0, PM, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b1, E_GR}, // R4
      {3'd0, PS, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0, E_GR}, // R4
      {3'd1, PU, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_IL}, // R5
      {3'd1, PS, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, E_IL}, // R5
      {3'd1, PS, 1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1, E_VF}, // R5
      {3'd1, PS, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b1, E_GR}, // R5
      {3'd1, PM, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, E_GR}, // R5
      {3'd1, PM, 1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, E_VF}, // R5
      {3'd2, PS, 1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_VF}, // R6
      {3'd2, PS, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, E_GR}, // R6
      {3'd2, PM, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_GR}, // R6
      {3'd2, PU, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_IL}, // R6
      {3'd2, PU, 1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_IL}, // R6
      {3'd3, PS, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, E_IL}, // R7
      {3'd3, PS, 1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, E_VF}, // R7
      {3'd3, PM, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0, E_GR}, // R7
      {3'd3, PS, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_GR}, // R7
      {3'd5, PM, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_IL}, // R10
      {3'd0, PR, 1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, E_IL}  // R10
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, wake_i = 1'b0;
   logic [CW-1:0] req_class = '0;
   logic [1:0] cur_priv = 2'd0;
   logic virt_on = 0, has_s_ext = 0, has_h_ext = 0;
   logic ctl_tw = 0, ctl_tvm = 0, ctl_vtw = 0, ctl_vtvm = 0;
   logic out_illegal, out_vfault, out_grant, out_flush, out_halt;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   priv_insn_gate #(.CLASS_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
      .cur_priv(cur_priv), .virt_on(virt_on), .has_s_ext(has_s_ext),
      .has_h_ext(has_h_ext), .ctl_tw(ctl_tw), .ctl_tvm(ctl_tvm),
      .ctl_vtw(ctl_vtw), .ctl_vtvm(ctl_vtvm), .wake_i(wake_i),
      .out_illegal(out_illegal), .out_vfault(out_vfault), .out_grant(out_grant),
      .out_flush(out_flush), .out_halt(out_halt)
   );

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {ill,vf,gr,flush,halt} actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic logic [4:0] outs();
      return {out_illegal, out_vfault, out_grant, out_flush, out_halt};
   endfunction

   task automatic present(input logic [11:0] f);
      @(negedge clk);
      {req_class, cur_priv, virt_on, has_s_ext, has_h_ext,
       ctl_tw, ctl_tvm, ctl_vtw, ctl_vtvm} = f;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      #1000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R1 in reset", outs(), 5'b00000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", outs(), 5'b00000);

      for (int i = 0; i < NV; i++) begin
         logic [1:0] e;
         logic is_wait, gr;
         e = VEC[i][1:0];
         is_wait = (VEC[i][13:11] == 3'd0);
         gr = (e == E_GR);
         present(VEC[i][13:2]);
         check($sformatf("R2/R3-R7/R10 vector %0d", i), outs(),
               {e == E_IL, e == E_VF, gr, gr && !is_wait, gr && is_wait && VEC[i][10:9] != PR});
         wake_i = 1'b1;
         @(negedge clk);
         wake_i = 1'b0;
         check($sformatf("R2 idle after vector %0d", i), outs(), 5'b00000);
      end

      // R9: halt held through idle cycles, released by wake
      present({3'd0, PM, 7'b0100000});
      check("R9 halt raised", outs(), 5'b00101);
      repeat (4) @(negedge clk);
      check("R9 halt held", outs(), 5'b00001);
      wake_i = 1'b1;
      @(negedge clk);
      wake_i = 1'b0;
      check("R9 halt released", outs(), 5'b00000);

      // R9: wake together with a new granted wait keeps the halt
      present({3'd0, PM, 7'b0100000});
      @(negedge clk);
      {req_class, cur_priv} = {3'd0, PM};
      req_valid = 1'b1;
      wake_i = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wake_i = 1'b0;
      check("R9 wake with new wait", outs(), 5'b00101);
      wake_i = 1'b1;
      @(negedge clk);
      wake_i = 1'b0;
      check("R9 final release", outs(), 5'b00000);

      // R8: granted fence pulses flush for one cycle only
      present({3'd1, PM, 7'b0000000});
      check("R8 flush pulse", outs(), 5'b00110);
      @(negedge clk);
      check("R8 flush gone", outs(), 5'b00000);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule